// File: doc/BRIEF.md
# Two-Level Page Table Walker

This block turns a 32-bit virtual address into a physical address by reading two page table entries from memory. A request carries the virtual address, whether the access is a write, and whether it comes from user mode. It also samples a base frame number that locates the top-level table. The walker reads the top-level entry, follows it to a second-level table, reads the leaf entry, and returns either the translated physical address or a fault code.

Each table holds 1024 four-byte entries and is indexed by a 10-bit slice of the virtual page number. The low 12 bits of the address are the offset inside a 4 KB page and are carried through unchanged. The walker finds two kinds of error and reports them with different codes. An entry whose valid bit is clear gives a not-present fault. A leaf whose rights forbid the access gives a protection fault. Memory reads go through a valid/ready request channel and a response valid strobe. The walker handles one walk at a time and reports the end of each walk with a single-cycle done pulse.

Top module: `pt_walker`

## Requirements
- R1: `req_ready` is high after reset and between walks. A request is taken on a cycle where `req_valid` and `req_ready` are both high, and `req_ready` stays low from that point until the walk's done pulse has passed.
- R2: The first memory read is at byte address `{ptbr_pfn, 12'h000} + vaddr[31:22]*4`, where `ptbr_pfn` is sampled when the request is taken.
- R3: The second memory read is at byte address `{pfn1, 12'h000} + vaddr[21:12]*4`, where `pfn1` is bits [31:12] of the first entry.
- R4: Entry layout: bit 0 valid, bit 1 writable, bit 2 user-accessible, bits [31:12] frame number. When the walk succeeds, `done_fault` is 0 and `done_paddr` is `{leaf frame number, vaddr[11:0]}`.
- R5: If the first entry has bit 0 clear, the walk ends with `done_fault` = 1 (not present) and `done_paddr` = 0, and no second read is issued.
- R6: If the leaf entry has bit 0 clear, the walk ends with `done_fault` = 1 and `done_paddr` = 0, whatever its rights bits hold.
- R7: A write (`req_write` = 1) to a valid leaf whose writable bit is 0 ends with `done_fault` = 2 (protection) and `done_paddr` = 0. Code 3 is never produced.
- R8: A user-mode access (`req_user` = 1) to a valid leaf whose user bit is 0 ends with `done_fault` = 2. A kernel-mode access to the same leaf is allowed if the write rule permits it.
- R9: With the default `CHECK_L1_RIGHTS` = 0, the writable and user bits of the first-level entry have no effect on the outcome.
- R10: `mem_req_valid` is low while idle. Once raised, it and `mem_req_addr` stay unchanged until `mem_req_ready` is seen, and every address is aligned to 4 bytes.
- R11: `done` is high for exactly one cycle per accepted request and is low after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Translation request present |
| req_ready | output | 1 | Walker idle and able to take a request |
| req_vaddr | input | 32 | Virtual address to translate |
| req_write | input | 1 | 1 = write access, 0 = read access |
| req_user | input | 1 | 1 = user mode, 0 = kernel mode |
| ptbr_pfn | input | 20 | Frame number of the top-level table |
| mem_req_valid | output | 1 | Memory read request valid |
| mem_req_ready | input | 1 | Memory accepts the read request |
| mem_req_addr | output | 32 | Byte address of the entry to read |
| mem_rsp_valid | input | 1 | Read data valid |
| mem_rsp_data | input | 32 | Entry read from memory |
| done | output | 1 | One-cycle pulse marking the end of a walk |
| done_fault | output | 2 | 0 none, 1 not present, 2 protection |
| done_paddr | output | 32 | Translated physical address, 0 on a fault |

## Verification
The hardest case to reach from the ports is the one where each level's checks give a different answer. Examples are a first-level entry that denies rights while its leaf allows them, and a leaf that is invalid while its rights bits are set. The bench writes a sparse entry memory so that one top-level slot points to a table with a user leaf, a kernel read-only leaf, a kernel writable leaf and an invalid leaf. Walks through that slot try every mode and access combination. The memory responder stalls the request channel and delays the response by random amounts, so the request must stay stable through a stall. The responder also checks that each address it receives is the next one the model expects, and that no second read follows a missing top-level entry.

// File: rtl/ptw_pkg.sv
package ptw_pkg;

   typedef enum logic [2:0] {
      WS_IDLE,
      WS_L1_REQ,
      WS_L1_WAIT,
      WS_L2_REQ,
      WS_L2_WAIT,
      WS_DONE
   } walk_state_t;

   localparam logic [1:0] FLT_NONE   = 2'd0;
   localparam logic [1:0] FLT_ABSENT = 2'd1;
   localparam logic [1:0] FLT_RIGHTS = 2'd2;

   localparam int PTE_BIT_V = 0;
   localparam int PTE_BIT_W = 1;
   localparam int PTE_BIT_U = 2;

   typedef struct packed {
      logic write;
      logic user;
   } access_t;

endpackage

// File: rtl/ptw_entry_addr.sv
module ptw_entry_addr #(
   parameter int PA_W      = 32,
   parameter int OFF_W     = 12,
   parameter int IDX_W     = 10,
   parameter int ENT_SHIFT = 2
) (
   input  logic [PA_W-OFF_W-1:0] base_pfn,
   input  logic [IDX_W-1:0]      idx,
   output logic [PA_W-1:0]       addr
);
   localparam int PAD_W = PA_W - IDX_W - ENT_SHIFT;

   logic [PA_W-1:0] base_byte;
   logic [PA_W-1:0] idx_byte;

   generate
      if (IDX_W + ENT_SHIFT > OFF_W) begin : g_bad_geom
         $error("table index plus entry size exceeds the page offset");
      end
   endgenerate

   assign base_byte = {base_pfn, {OFF_W{1'b0}}};
   assign idx_byte  = {{PAD_W{1'b0}}, idx, {ENT_SHIFT{1'b0}}};
   assign addr      = base_byte + idx_byte;

endmodule

// File: rtl/ptw_pte_check.sv
module ptw_pte_check
   import ptw_pkg::*;
#(
   parameter int  PTE_W        = 32,
   parameter int  OFF_W        = 12,
   parameter bit  CHECK_RIGHTS = 1'b1
) (
   input  logic [PTE_W-1:0]       pte,
   input  access_t                acc,
   output logic [1:0]             fault,
   output logic [PTE_W-OFF_W-1:0] pfn
);
   logic present;
   logic rights_bad;
   logic unused_low;

   assign present    = pte[PTE_BIT_V];
   assign unused_low = ^pte[OFF_W-1:PTE_BIT_U+1];

   generate
      if (CHECK_RIGHTS) begin : g_rights
         assign rights_bad = (acc.write & ~pte[PTE_BIT_W]) |
                             (acc.user  & ~pte[PTE_BIT_U]);
      end else begin : g_valid_only
         logic unused_rights;
         assign unused_rights = ^{acc, pte[PTE_BIT_U:PTE_BIT_W]};
         assign rights_bad    = 1'b0;
      end
   endgenerate

   always_comb begin
      if (!present)        fault = FLT_ABSENT;
      else if (rights_bad) fault = FLT_RIGHTS;
      else                 fault = FLT_NONE;
   end

   assign pfn = pte[PTE_W-1:OFF_W];

endmodule

// File: rtl/pt_walker.sv
module pt_walker
   import ptw_pkg::*;
#(
   parameter int VA_W            = 32,
   parameter int PA_W            = 32,
   parameter int OFF_W           = 12,
   parameter int IDX_W           = 10,
   parameter int ENTRY_BYTES     = 4,
   parameter bit CHECK_L1_RIGHTS = 1'b0
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  req_valid,
   output logic                  req_ready,
   input  logic [VA_W-1:0]       req_vaddr,
   input  logic                  req_write,
   input  logic                  req_user,
   input  logic [PA_W-OFF_W-1:0] ptbr_pfn,
   output logic                  mem_req_valid,
   input  logic                  mem_req_ready,
   output logic [PA_W-1:0]       mem_req_addr,
   input  logic                  mem_rsp_valid,
   input  logic [PA_W-1:0]       mem_rsp_data,
   output logic                  done,
   output logic [1:0]            done_fault,
   output logic [PA_W-1:0]       done_paddr
);
   localparam int PFN_W     = PA_W - OFF_W;
   localparam int ENT_SHIFT = $clog2(ENTRY_BYTES);
   localparam int PTE_W     = 8 * ENTRY_BYTES;
   localparam int L1_LSB    = OFF_W + IDX_W;
   localparam int L2_LSB    = OFF_W;

   generate
      if (VA_W != OFF_W + 2 * IDX_W) begin : g_bad_va
         $error("virtual address must split into two indices and an offset");
      end
      if (PTE_W != PA_W) begin : g_bad_pte
         $error("entry width must equal the physical address width");
      end
   endgenerate

   walk_state_t       state;
   logic [VA_W-1:0]   va_q;
   access_t           acc_q;
   logic [PFN_W-1:0]  base_q;
   logic [1:0]        fault_q;
   logic [PA_W-1:0]   paddr_q;

   logic [IDX_W-1:0]  idx_sel;
   logic [1:0]        l1_fault;
   logic [1:0]        l2_fault;
   logic [PFN_W-1:0]  l1_pfn;
   logic [PFN_W-1:0]  l2_pfn;
   access_t           req_acc;

   assign req_acc.write = req_write;
   assign req_acc.user  = req_user;

   assign idx_sel = (state == WS_L2_REQ) ? va_q[L2_LSB +: IDX_W]
                                         : va_q[L1_LSB +: IDX_W];

   ptw_entry_addr #(
      .PA_W      (PA_W),
      .OFF_W     (OFF_W),
      .IDX_W     (IDX_W),
      .ENT_SHIFT (ENT_SHIFT)
   ) u_addr (
      .base_pfn (base_q),
      .idx      (idx_sel),
      .addr     (mem_req_addr)
   );

   ptw_pte_check #(
      .PTE_W        (PTE_W),
      .OFF_W        (OFF_W),
      .CHECK_RIGHTS (CHECK_L1_RIGHTS)
   ) u_chk_l1 (
      .pte   (mem_rsp_data),
      .acc   (acc_q),
      .fault (l1_fault),
      .pfn   (l1_pfn)
   );

   ptw_pte_check #(
      .PTE_W        (PTE_W),
      .OFF_W        (OFF_W),
      .CHECK_RIGHTS (1'b1)
   ) u_chk_l2 (
      .pte   (mem_rsp_data),
      .acc   (acc_q),
      .fault (l2_fault),
      .pfn   (l2_pfn)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state   <= WS_IDLE;
         va_q    <= '0;
         acc_q   <= '0;
         base_q  <= '0;
         fault_q <= FLT_NONE;
         paddr_q <= '0;
      end else begin
         unique case (state)
            WS_IDLE: begin
               if (req_valid) begin
                  va_q    <= req_vaddr;
                  acc_q   <= req_acc;
                  base_q  <= ptbr_pfn;
                  fault_q <= FLT_NONE;
                  paddr_q <= '0;
                  state   <= WS_L1_REQ;
               end
            end
            WS_L1_REQ: begin
               if (mem_req_ready) state <= WS_L1_WAIT;
            end
            WS_L1_WAIT: begin
               if (mem_rsp_valid) begin
                  if (l1_fault != FLT_NONE) begin
                     fault_q <= l1_fault;
                     state   <= WS_DONE;
                  end else begin
                     base_q <= l1_pfn;
                     state  <= WS_L2_REQ;
                  end
               end
            end
            WS_L2_REQ: begin
               if (mem_req_ready) state <= WS_L2_WAIT;
            end
            WS_L2_WAIT: begin
               if (mem_rsp_valid) begin
                  if (l2_fault != FLT_NONE) begin
                     fault_q <= l2_fault;
                  end else begin
                     paddr_q <= {l2_pfn, va_q[OFF_W-1:0]};
                  end
                  state <= WS_DONE;
               end
            end
            WS_DONE: state <= WS_IDLE;
            default: state <= WS_IDLE;
         endcase
      end
   end

   assign req_ready     = (state == WS_IDLE);
   assign mem_req_valid = (state == WS_L1_REQ) || (state == WS_L2_REQ);
   assign done          = (state == WS_DONE);
   assign done_fault    = fault_q;
   assign done_paddr    = paddr_q;

endmodule

// File: rtl/pt_walker_chk.sv
module pt_walker_chk #(
   parameter int VA_W        = 32,
   parameter int PA_W        = 32,
   parameter int OFF_W       = 12,
   parameter int ENTRY_BYTES = 4
) (
   input logic                  clk,
   input logic                  rst_n,
   input logic                  req_valid,
   input logic                  req_ready,
   input logic [VA_W-1:0]       req_vaddr,
   input logic                  mem_req_valid,
   input logic                  mem_req_ready,
   input logic [PA_W-1:0]       mem_req_addr,
   input logic                  done,
   input logic [1:0]            done_fault,
   input logic [PA_W-1:0]       done_paddr
);
   localparam int ENT_SHIFT = $clog2(ENTRY_BYTES);

   logic [OFF_W-1:0] cap_off;
   logic             unused_va;

   assign unused_va = ^req_vaddr[VA_W-1:OFF_W];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                      cap_off <= '0;
      else if (req_valid && req_ready) cap_off <= req_vaddr[OFF_W-1:0];
   end

   AST_IDLE_NO_MEM: assert property (@(posedge clk) disable iff (!rst_n)
      req_ready |-> !mem_req_valid);                                  // R10
   AST_TAKEN_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid && req_ready |=> !req_ready);                         // R1
   AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req_valid && !mem_req_ready |=> mem_req_valid && $stable(mem_req_addr)); // R10
   AST_ADDR_ALIGN: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req_valid |-> mem_req_addr[ENT_SHIFT-1:0] == '0);           // R10
   AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);                                                // R11
   AST_FAULT_NO_XLATE: assert property (@(posedge clk) disable iff (!rst_n)
      done && done_fault != 2'd0 |-> done_paddr == '0);               // R5
   AST_FAULT_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> done_fault != 2'd3);                                   // R7
   AST_OFFSET_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
      done && done_fault == 2'd0 |-> done_paddr[OFF_W-1:0] == cap_off); // R4

endmodule

bind pt_walker pt_walker_chk #(
   .VA_W        (VA_W),
   .PA_W        (PA_W),
   .OFF_W       (OFF_W),
   .ENTRY_BYTES (ENTRY_BYTES)
) u_walker_chk (
   .clk           (clk),
   .rst_n         (rst_n),
   .req_valid     (req_valid),
   .req_ready     (req_ready),
   .req_vaddr     (req_vaddr),
   .mem_req_valid (mem_req_valid),
   .mem_req_ready (mem_req_ready),
   .mem_req_addr  (mem_req_addr),
   .done          (done),
   .done_fault    (done_fault),
   .done_paddr    (done_paddr)
);

// File: tb/pt_walker_test.sv
module pt_walker_test;
   localparam int CLK_PERIOD = 10;

   logic        clk = 1'b0;
   logic        rst_n;
   logic        req_valid;
   logic        req_ready;
   logic [31:0] req_vaddr;
   logic        req_write;
   logic        req_user;
   logic [19:0] ptbr_pfn;
   logic        mem_req_valid;
   logic        mem_req_ready;
   logic [31:0] mem_req_addr;
   logic        mem_rsp_valid;
   logic [31:0] mem_rsp_data;
   logic        done;
   logic [1:0]  done_fault;
   logic [31:0] done_paddr;

   always #(CLK_PERIOD/2) clk = ~clk;

   pt_walker uut (
      .clk           (clk),
      .rst_n         (rst_n),
      .req_valid     (req_valid),
      .req_ready     (req_ready),
      .req_vaddr     (req_vaddr),
      .req_write     (req_write),
      .req_user      (req_user),
      .ptbr_pfn      (ptbr_pfn),
      .mem_req_valid (mem_req_valid),
      .mem_req_ready (mem_req_ready),
      .mem_req_addr  (mem_req_addr),
      .mem_rsp_valid (mem_rsp_valid),
      .mem_rsp_data  (mem_rsp_data),
      .done          (done),
      .done_fault    (done_fault),
      .done_paddr    (done_paddr)
   );

   typedef struct {
      logic [31:0] paddr;
      logic [1:0]  fault;
      string       req;
   } exp_t;

   exp_t        exp_q[$];
   logic [31:0] addr_q[$];
   string       addr_req_q[$];
   bit [31:0]   mem [bit [31:0]];
   int          n_chk = 0;
   int          n_bad = 0;
   int          done_cnt = 0;
   bit          finished = 1'b0;

   function automatic bit [31:0] rd(input bit [31:0] a);
      return mem.exists(a) ? mem[a] : 32'h0;
   endfunction

   task automatic check(input bit ok, input string req,
                        input logic [31:0] act, input logic [31:0] expv);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s actual=%h expected=%h", req, act, expv);
      end
   endtask

   task automatic summary();
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
   endtask

   // driver: computes the expected walk from the entry memory, then issues it
   task automatic walk(input logic [31:0] va, input bit wr, input bit usr,
                       input string req);
      exp_t        e;
      bit   [31:0] a1, a2, p1, p2;
      int          start;
      a1 = {ptbr_pfn, 12'h000} + {20'h0, va[31:22], 2'b00};
      p1 = rd(a1);
      addr_q.push_back(a1); addr_req_q.push_back({req, " R2"});
      e.req = req;
      if (!p1[0]) begin
         e.fault = 2'd1; e.paddr = 32'h0;
      end else begin
         a2 = {p1[31:12], 12'h000} + {20'h0, va[21:12], 2'b00};
         p2 = rd(a2);
         addr_q.push_back(a2); addr_req_q.push_back({req, " R3"});
         if (!p2[0]) begin
            e.fault = 2'd1; e.paddr = 32'h0;
         end else if ((wr && !p2[1]) || (usr && !p2[2])) begin
            e.fault = 2'd2; e.paddr = 32'h0;
         end else begin
            e.fault = 2'd0; e.paddr = {p2[31:12], va[11:0]};
         end
      end
      exp_q.push_back(e);
      start = done_cnt;
      @(negedge clk);
      req_valid = 1'b1; req_vaddr = va; req_write = wr; req_user = usr;
      while (!req_ready) @(negedge clk);
      @(negedge clk);
      req_valid = 1'b0; req_vaddr = 32'hDEAD_BEEF;
      check(req_ready == 1'b0, "R1 busy after accept", {31'h0, req_ready}, 32'h0);
      wait (done_cnt != start);
      @(negedge clk);
      check(req_ready == 1'b1, "R1 idle after done", {31'h0, req_ready}, 32'h1);
   endtask

   // memory responder: random stalls and latency, checks each address
   initial begin
      mem_req_ready = 1'b0;
      mem_rsp_valid = 1'b0;
      mem_rsp_data  = 32'h0;
      forever begin
         @(negedge clk);
         mem_rsp_valid = 1'b0;
         mem_req_ready = ($urandom_range(0, 2) != 0);
         if (rst_n && mem_req_valid && mem_req_ready) begin
            logic [31:0] a;
            int          lat;
            a = mem_req_addr;
            if (addr_q.size() == 0) begin
               check(1'b0, "R5 unexpected read", a, 32'h0);
            end else begin
               logic [31:0] ea;
               string       er;
               ea = addr_q.pop_front();
               er = addr_req_q.pop_front();
               check(a == ea, er, a, ea);
            end
            lat = $urandom_range(0, 3);
            @(negedge clk);
            mem_req_ready = 1'b0;
            repeat (lat) @(negedge clk);
            mem_rsp_valid = 1'b1;
            mem_rsp_data  = rd(a);
         end
      end
   end

   // monitor: pops the scoreboard on every done pulse
   initial begin
      forever begin
         @(negedge clk);
         if (rst_n && done) begin
            if (exp_q.size() == 0) begin
               check(1'b0, "R11 extra done", 32'h1, 32'h0);
            end else begin
               exp_t e;
               e = exp_q.pop_front();
               check(done_fault == e.fault, {e.req, " fault"},
                     {30'h0, done_fault}, {30'h0, e.fault});
               check(done_paddr == e.paddr, {e.req, " paddr"}, done_paddr, e.paddr);
            end
            done_cnt++;
            @(negedge clk);
            check(done == 1'b0, "R11 pulse width", {31'h0, done}, 32'h0);
         end
      end
   end

   initial begin
      #(CLK_PERIOD * 100000);
      if (!finished) begin
         n_chk++; n_bad++;
         $display("FAIL watchdog expired actual=hung expected=finished");
         summary();
         $finish;
      end
   end

   initial begin
      rst_n = 1'b0; req_valid = 1'b0; req_vaddr = 32'h0;
      req_write = 1'b0; req_user = 1'b0; ptbr_pfn = 20'h00100;
      // top table at 0x00100000
      mem[32'h0010_0004] = 32'h0020_0007;  // slot 1 -> table 0x200000, all rights
      mem[32'h0010_0008] = 32'h0040_0006;  // slot 2 invalid
      mem[32'h0010_0FFC] = 32'h0030_0001;  // slot 1023 -> table 0x300000, no rights
      // leaves in table 0x200000
      mem[32'h0020_000C] = 32'hABCD_E007;  // user rw
      mem[32'h0020_0010] = 32'h1234_5001;  // kernel read-only
      mem[32'h0020_0014] = 32'h5555_5005;  // user read-only
      mem[32'h0020_0018] = 32'h7777_7003;  // kernel rw
      mem[32'h0020_001C] = 32'h9999_9006;  // invalid, rights set
      mem[32'h0030_0FFC] = 32'hFFFF_F007;  // last leaf, user rw
      repeat (3) @(negedge clk);
      check(req_ready == 1'b1, "R1 reset ready", {31'h0, req_ready}, 32'h1);
      check(mem_req_valid == 1'b0, "R10 reset mem idle", {31'h0, mem_req_valid}, 32'h0);
      check(done == 1'b0, "R11 reset done", {31'h0, done}, 32'h0);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);

      walk(32'h0040_35A4, 1'b0, 1'b1, "R4 user read rw leaf");
      walk(32'h0040_3FFF, 1'b1, 1'b1, "R4 user write rw leaf");
      walk(32'h0040_4010, 1'b0, 1'b0, "R8 kernel read ro leaf");
      walk(32'h0040_4010, 1'b1, 1'b0, "R7 kernel write ro leaf");
      walk(32'h0040_4010, 1'b0, 1'b1, "R8 user read kernel leaf");
      walk(32'h0040_5800, 1'b0, 1'b1, "R8 user read user-ro leaf");
      walk(32'h0040_5800, 1'b1, 1'b1, "R7 user write user-ro leaf");
      walk(32'h0040_6123, 1'b1, 1'b0, "R7 kernel write rw leaf");
      walk(32'h0040_6123, 1'b1, 1'b1, "R8 user write kernel rw leaf");
      walk(32'h0040_7000, 1'b1, 1'b1, "R6 invalid leaf");
      walk(32'h0080_0000, 1'b0, 1'b0, "R5 invalid top entry");
      walk(32'h0000_0123, 1'b0, 1'b0, "R5 empty top slot 0");
      walk(32'hFFFF_FFFF, 1'b1, 1'b1, "R9 top rights ignored");
      walk(32'h0040_8000, 1'b0, 1'b0, "R6 unwritten leaf");
      for (int i = 0; i < 6; i++) begin
         walk({10'h001, 10'(3 + (i % 5)), 12'(i * 333)}, 1'(i & 1), 1'(i >> 1 & 1),
              "R4 mixed walk");
      end

      repeat (5) @(negedge clk);
      check(addr_q.size() == 0, "R5 reads left unissued", addr_q.size(), 32'h0);
      check(exp_q.size() == 0, "R11 results missing", exp_q.size(), 32'h0);
      finished = 1'b1;
      summary();
      $finish;
   end

endmodule